// File: doc/BRIEF.md
# Mode-Switched Memory Map Decoder

This block turns the upper bits of a 16-bit address into active-low chip selects for a small 8-bit computer. The selects cover the monitor ROM, the video and workspace RAM, the BASIC ROMs, a bank of auxiliary ROM sockets and a switchable 4K RAM block. The address space is cut into 2K slots, and two mode inputs decide which select each slot drives. One input picks between the monitor map and the CP/M map. The other picks between BASIC and DISK. Every select is gated by the memory request input.

A small control part also steers the first instruction fetch after reset. It raises a jump override flag and drives four address-control bits that point at the mode's start address: 0000H for the monitor map and F000H for the CP/M map. The first memory request seen on a clock edge after reset clears the flag. It then stays clear until the next reset.

Top module: `memmap_decoder`

## Requirements
- R1: In the monitor map (cpmMode=0), an address in 0000H–07FFH with memReq=1 drives monRomCsN low. In the CP/M map, monRomCsN never goes low.
- R2: In the monitor map, an address in 0800H–0FFFH with memReq=1 drives videoCsN low.
- R3: In BASIC mode (diskMode=0, cpmMode=0), every address in E000H–FFFFH with memReq=1 drives basicCsN low.
- R4: Whenever diskMode=1 or cpmMode=1, basicCsN stays high. Addresses in E000H–EFFFH then drive no select at all.
- R5: With diskMode=1 and cpmMode=0, addresses in F000H–FFFFH drive auxRomCsN low.
- R6: In the CP/M map, addresses in 0000H–0FFFH drive lowRamCsN low. lowRamCsN is never low in the monitor map.
- R7: In the CP/M map, F800H–FFFFH drives videoCsN low and F000H–F7FFH drives auxRomCsN low.
- R8: cpmMode=1 with diskMode=0 is decoded exactly like cpmMode=1 with diskMode=1.
- R9: With memReq=0, all five selects stay high for any address and mode.
- R10: At most one select is low at any time, in every mode and for every slot.
- R11: jumpActive is 1 while rstN is low and after rstN rises. It goes to 0 on the first rising clock edge where memReq=1, then stays 0 until the next reset.
- R12: While jumpActive=1, jumpAddr is 4'b0000 when cpmMode=0 and 4'b1111 when cpmMode=1. While jumpActive=0, jumpAddr is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the jump override state |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address bus |
| memReq | input | 1 | Memory request, active high |
| cpmMode | input | 1 | 1 selects the CP/M map, 0 the monitor map |
| diskMode | input | 1 | 1 selects DISK, 0 selects BASIC |
| monRomCsN | output | 1 | Monitor ROM select, active low |
| videoCsN | output | 1 | Video/workspace RAM select, active low |
| basicCsN | output | 1 | BASIC ROM select, active low |
| auxRomCsN | output | 1 | Auxiliary ROM socket bank select, active low |
| lowRamCsN | output | 1 | 4K low RAM block select, active low |
| jumpActive | output | 1 | Power-on jump override in force |
| jumpAddr | output | 4 | Override address-control bits |

## Verification
The bench builds the block with its default parameters: a 16-bit address split into 2K slots, which gives 32 slots and a 4-bit jump field. With these values every slot can be swept in all four combinations of the mode inputs, so the whole decode table and the at-most-one-select property are checked exhaustively rather than by sampling. The jump override is checked after two resets, one in each map. This shows that the override holds through idle cycles without a memory request and clears on the first one.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  // Mode strobes handed from control to datapath
  typedef struct packed {
    logic cpmMap;    // low 4K is RAM, video moves to top slot
    logic basicMap;  // top four slots feed BASIC ROM
  } modeStrobe_t;

endpackage

// File: rtl/memmap_ctrl.sv
module memmap_ctrl
  import memmap_pkg::*;
#(
  parameter int JUMP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memReq,
  input  logic              cpmMode,
  input  logic              diskMode,
  output modeStrobe_t       strobes,
  output logic              jumpActive,
  output logic [JUMP_W-1:0] jumpAddr
);

  logic jumpPending;

  // CP/M overrides BASIC: a CP/M request is always treated as DISK
  always_comb begin
    strobes.cpmMap   = cpmMode;
    strobes.basicMap = !diskMode && !cpmMode;
  end

  // Override holds from reset until the first sampled memory request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      jumpPending <= 1'b1;
    end else if (memReq) begin
      jumpPending <= 1'b0;
    end
  end

  assign jumpActive = jumpPending;
  assign jumpAddr   = (jumpPending && cpmMode) ? {JUMP_W{1'b1}} : '0;

endmodule

// File: rtl/memmap_datapath.sv
module memmap_datapath
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              memReq,
  input  modeStrobe_t       strobes,
  output logic              monRomCsN,
  output logic              videoCsN,
  output logic              basicCsN,
  output logic              auxRomCsN,
  output logic              lowRamCsN
);

  localparam int IDX_W     = ADDR_W - SLOT_W;
  localparam int NUM_SLOTS = 1 << IDX_W;
  localparam int TOP_SLOT  = NUM_SLOTS - 1;
  localparam int AUX_SLOT  = NUM_SLOTS - 2;
  localparam int BAS_FIRST = NUM_SLOTS - 4;

  logic [NUM_SLOTS-1:0] slotHit;
  logic monHit, vidHit, basHit, auxHit, ramHit;

  // One decode line per 2K slot, qualified by memory request
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slotHit[s] = memReq && (addr[ADDR_W-1:SLOT_W] == IDX_W'(s));
  end

  always_comb begin
    monHit = slotHit[0] && !strobes.cpmMap;
    ramHit = (slotHit[0] || slotHit[1]) && strobes.cpmMap;
    vidHit = (slotHit[1] && !strobes.cpmMap) ||
             (slotHit[TOP_SLOT] && strobes.cpmMap);
    basHit = strobes.basicMap && (|slotHit[TOP_SLOT:BAS_FIRST]);
    auxHit = !strobes.basicMap &&
             (slotHit[AUX_SLOT] || (slotHit[TOP_SLOT] && !strobes.cpmMap));
  end

  assign monRomCsN = !monHit;
  assign videoCsN  = !vidHit;
  assign basicCsN  = !basHit;
  assign auxRomCsN = !auxHit;
  assign lowRamCsN = !ramHit;

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 11,
  parameter int JUMP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              memReq,
  input  logic              cpmMode,
  input  logic              diskMode,
  output logic              monRomCsN,
  output logic              videoCsN,
  output logic              basicCsN,
  output logic              auxRomCsN,
  output logic              lowRamCsN,
  output logic              jumpActive,
  output logic [JUMP_W-1:0] jumpAddr
);

  modeStrobe_t strobes;

  memmap_ctrl #(.JUMP_W(JUMP_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .memReq     (memReq),
    .cpmMode    (cpmMode),
    .diskMode   (diskMode),
    .strobes    (strobes),
    .jumpActive (jumpActive),
    .jumpAddr   (jumpAddr)
  );

  memmap_datapath #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_dp (
    .addr      (addr),
    .memReq    (memReq),
    .strobes   (strobes),
    .monRomCsN (monRomCsN),
    .videoCsN  (videoCsN),
    .basicCsN  (basicCsN),
    .auxRomCsN (auxRomCsN),
    .lowRamCsN (lowRamCsN)
  );

endmodule

// File: rtl/memmap_checker.sv
module memmap_checker #(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 11,
  parameter int JUMP_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              memReq,
  input logic              cpmMode,
  input logic              diskMode,
  input logic              monRomCsN,
  input logic              videoCsN,
  input logic              basicCsN,
  input logic              auxRomCsN,
  input logic              lowRamCsN,
  input logic              jumpActive,
  input logic [JUMP_W-1:0] jumpAddr
);

  logic [4:0] selLow;
  assign selLow = ~{monRomCsN, videoCsN, basicCsN, auxRomCsN, lowRamCsN};

  assert_one_select_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selLow));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !memReq |-> (selLow == 5'b0));

  assert_no_basic_R4: assert property (@(posedge clk) disable iff (!rstN)
    (diskMode || cpmMode) |-> basicCsN);

  assert_no_monitor_cpm_R1: assert property (@(posedge clk) disable iff (!rstN)
    cpmMode |-> monRomCsN);

  assert_no_ram_monitor_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cpmMode |-> lowRamCsN);

  assert_jump_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !jumpActive);

  assert_jump_stays_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    !jumpActive |=> !jumpActive);

  assert_jump_bits_R12: assert property (@(posedge clk) disable iff (!rstN)
    jumpAddr == ((jumpActive && cpmMode) ? {JUMP_W{1'b1}} : {JUMP_W{1'b0}}));

endmodule

bind memmap_decoder memmap_checker #(
  .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .JUMP_W(JUMP_W)
) u_chk (.*);

// File: tb/sim_memmap_decoder.sv
module sim_memmap_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = '0;
  logic        memReq = 1'b0;
  logic        cpmMode = 1'b0;
  logic        diskMode = 1'b0;
  logic        monRomCsN, videoCsN, basicCsN, auxRomCsN, lowRamCsN;
  logic        jumpActive;
  logic [3:0]  jumpAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  memmap_decoder u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .memReq(memReq),
    .cpmMode(cpmMode), .diskMode(diskMode),
    .monRomCsN(monRomCsN), .videoCsN(videoCsN), .basicCsN(basicCsN),
    .auxRomCsN(auxRomCsN), .lowRamCsN(lowRamCsN),
    .jumpActive(jumpActive), .jumpAddr(jumpAddr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] selNow();
    return {monRomCsN, videoCsN, basicCsN, auxRomCsN, lowRamCsN};
  endfunction

  // Expected active-low selects {mon, video, basic, aux, ram}
  function automatic logic [4:0] expSel(int slot, bit cpm, bit disk, bit req);
    logic [4:0] low = '0;
    bit basic = !disk && !cpm;
    if (!req) return 5'b11111;
    if (cpm) begin
      if (slot == 0 || slot == 1) low[0] = 1'b1;   // R6
      if (slot == 31)             low[3] = 1'b1;   // R7
      if (slot == 30)             low[1] = 1'b1;   // R7
    end else begin
      if (slot == 0) low[4] = 1'b1;                // R1
      if (slot == 1) low[3] = 1'b1;                // R2
      if (basic && slot >= 28) low[2] = 1'b1;      // R3
      if (!basic && slot >= 30) low[1] = 1'b1;     // R5
    end
    return ~low;
  endfunction

  task automatic doReset(input bit cpm);
    cpmMode = cpm; diskMode = cpm; memReq = 1'b0;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); #1;
    check(jumpActive == 1'b1, "R11", "active during reset", jumpActive, 1);
    check(selNow() == 5'b11111, "R9", "selects idle in reset", selNow(), 5'b11111);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic testJump(input bit cpm);
    logic [3:0] want = cpm ? 4'hF : 4'h0;
    repeat (3) @(negedge clk);
    check(jumpActive == 1'b1, "R11", "held with no request", jumpActive, 1);
    check(jumpAddr == want, "R12", "jump bits while active", jumpAddr, want);
    addr = 16'h0000; memReq = 1'b1;
    @(posedge clk); #2;
    check(jumpActive == 1'b0, "R11", "cleared by first fetch", jumpActive, 0);
    check(jumpAddr == 4'h0, "R12", "jump bits after clear", jumpAddr, 0);
    @(negedge clk); memReq = 1'b0;
    repeat (3) @(negedge clk);
    check(jumpActive == 1'b0, "R11", "stays clear", jumpActive, 0);
  endtask

  task automatic probe(input logic [15:0] a, input bit cpm, input bit disk,
                       input bit req, input string tag);
    @(negedge clk);
    addr = a; cpmMode = cpm; diskMode = disk; memReq = req;
    #2;
    check(selNow() == expSel(int'(a[15:11]), cpm, disk, req), tag,
          $sformatf("addr %h cpm %0d disk %0d req %0d", a, cpm, disk, req),
          selNow(), expSel(int'(a[15:11]), cpm, disk, req));
  endtask

  task automatic testDirected();
    probe(16'h0123, 0, 0, 1, "R1");
    probe(16'h07FF, 0, 1, 1, "R1");
    probe(16'h0800, 0, 0, 1, "R2");
    probe(16'h0FFF, 0, 1, 1, "R2");
    probe(16'hE000, 0, 0, 1, "R3");
    probe(16'hFFFF, 0, 0, 1, "R3");
    probe(16'hE400, 0, 1, 1, "R4");
    probe(16'hEFFF, 1, 1, 1, "R4");
    probe(16'hF000, 0, 1, 1, "R5");
    probe(16'hF9AB, 0, 1, 1, "R5");
    probe(16'h0000, 1, 1, 1, "R6");
    probe(16'h0C00, 1, 1, 1, "R6");
    probe(16'hF800, 1, 1, 1, "R7");
    probe(16'hF7FF, 1, 1, 1, "R7");
    probe(16'h0456, 1, 0, 1, "R8");
    probe(16'hE123, 1, 0, 1, "R8");
    probe(16'hFC00, 1, 0, 1, "R8");
    probe(16'h0000, 0, 0, 0, "R9");
    probe(16'hE000, 0, 0, 0, "R9");
    probe(16'hF800, 1, 1, 0, "R9");
  endtask

  task automatic testSweep();
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 32; s++) begin
        probe(16'((s << 11) | 16'h03A5), m[1], m[0], 1, "R10");
        check($countones(~selNow()) <= 1, "R10", "at most one select",
              $countones(~selNow()), 1);
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    doReset(1'b0);
    testJump(1'b0);
    testDirected();
    testSweep();
    doReset(1'b1);
    testJump(1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule